// File: doc/BRIEF.md
# Error-Vector Sector Classifier and Voltage-Vector Proposer

This block sits in the current loop of a three-level clamped-midpoint inverter. Each sample gives it a signed fixed-point current-error vector in the stationary alpha/beta frame and the outer band radius for that sample. The block places the tip of the error vector in one of three rings around the origin. The innermost ring uses a fixed radius set by a parameter. The outer boundary uses the radius supplied on a port. The block then finds the angular sector of the tip and proposes a candidate inverter voltage-vector index to a downstream supervisor. The supervisor decides what is actually applied.

The sector map depends on the state of the DC-link midpoint:
- **Balanced midpoint:** the plane is cut into twelve 30° sectors. Odd sectors point at the large hexagon and even sectors at the medium hexagon.
- **Unbalanced midpoint:** the plane is cut into six 60° sectors, and only small vectors are proposed. A capacitor-charge request chooses between the charging family and the discharging family.

Inside the inner ring, no active vector is proposed. A zero-vector request is raised instead. The angle is resolved by folding the vector into the first quadrant and comparing slopes against one Q1.15 tangent constant, so no trigonometric core is needed. The result is registered, with one cycle of latency.

Top module: `errvec_selector`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs clear on that edge: `out_valid`, `out_area`, `out_sector`, `out_vec` and `out_zero` all become 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The other outputs change only on such edges and hold their values otherwise.
- R3: If alpha²+beta² is below INNER_RAD², the block reports area code 0 (inner), sector 0, vector index 0 and `out_zero`=1, in either midpoint mode.
- R4: If the squared magnitude is at least INNER_RAD² and below `outer_rad`², the area code is 1 (band). If it is at least `outer_rad`², the area code is 2 (outer). A magnitude exactly equal to a radius belongs to the larger ring.
- R5: In balanced mode (`np_balanced`=1), the error angle θ from the +alpha axis gives sector k (1..12) for θ in (30(k-1)°, 30k°]. θ = 0° gives sector 1.
- R6: In balanced mode outside the inner ring, an odd sector k proposes large-hexagon index 15+(k-1)/2 (15..20), and an even sector k proposes medium-hexagon index 8+(k-2)/2 (8..13). `cap_charge` has no effect in this mode.
- R7: In unbalanced mode (`np_balanced`=0), θ gives sector m (1..6) for θ in (60(m-1)°, 60m°]. θ = 0° gives sector 1.
- R8: In unbalanced mode outside the inner ring, `cap_charge`=1 proposes index m (1..6) and `cap_charge`=0 proposes index 20+m (21..26).
- R9: An angle lying exactly on a sector boundary is assigned to the lower-numbered sector. Examples: 90° gives sector 3 in balanced mode and sector 2 in unbalanced mode; 180° gives 6 and 3; 270° gives 9 and 5.
- R10: `out_zero` is 0 whenever the area is band or outer. `outer_rad` is taken fresh with every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| err_alpha | input | W | Signed alpha component of the current error |
| err_beta | input | W | Signed beta component of the current error |
| outer_rad | input | W | Unsigned outer band radius for this sample |
| np_balanced | input | 1 | 1 = midpoint balanced (12-sector map), 0 = unbalanced (6-sector map) |
| cap_charge | input | 1 | Unbalanced mode: 1 = charge upper capacitor |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_area | output | 2 | 0 inner, 1 band, 2 outer |
| out_sector | output | 4 | Sector number, 0 inside the inner ring |
| out_vec | output | 5 | Proposed voltage-vector index |
| out_zero | output | 1 | Zero-vector request |

## Verification
The bench targets the angles where folding goes wrong:
- **Axis points.** The points at 90°, 180° and 270° test the boundary rule. A quadrant split that treats a zero component as positive or negative in the wrong place moves these points to the upper sector, for example reporting 10 instead of 9.
- **Full sweep and extreme input.** Mid-sector points in all twelve sectors, in both modes, expose a swapped mirror formula in the second or fourth quadrant. The full-scale negative input exposes an absolute value that overflows.
- **Radius edges.** Points exactly on the inner and outer radii catch a strict-versus-inclusive error in the ring test.
- **Mode flags.** Pairs of samples that differ only in `cap_charge` or `np_balanced` catch a family chosen from the wrong flag.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [1:0] {
        AREA_INNER = 2'd0,
        AREA_BAND  = 2'd1,
        AREA_OUTER = 2'd2
    } area_e;

    localparam int SECT_W = 4;
    localparam int VEC_W  = 5;

    localparam logic [VEC_W-1:0] BASE_MED = 5'd8;
    localparam logic [VEC_W-1:0] BASE_LRG = 5'd15;
    localparam logic [VEC_W-1:0] BASE_CHG = 5'd1;
    localparam logic [VEC_W-1:0] BASE_DIS = 5'd21;

    typedef struct packed {
        area_e              area;
        logic [SECT_W-1:0]  sector;
        logic [VEC_W-1:0]   vec;
        logic               zero;
    } sel_t;

    // Merge two neighbouring 30-degree sectors into one 60-degree sector.
    function automatic logic [SECT_W-1:0] fold_to_six(input logic [SECT_W-1:0] s12);
        return (s12 + 4'd1) >> 1;
    endfunction

    // Position inside a folded quadrant: 0 below 30 deg, 1 up to 60 deg, 2 above.
    function automatic logic [1:0] sub_region(input logic below30, input logic below60);
        return below30 ? 2'd0 : (below60 ? 2'd1 : 2'd2);
    endfunction

endpackage

// File: rtl/evs_area.sv
module evs_area
    import evs_pkg::*;
#(
    parameter int W         = 16,
    parameter int INNER_RAD = 64
) (
    input  logic [W-1:0] ax,
    input  logic [W-1:0] bx,
    input  logic [W-1:0] outer_rad,
    output area_e        area
);
    localparam int MW = 2*W + 1;
    localparam logic [MW-1:0] INNER_SQ = MW'(INNER_RAD * INNER_RAD);

    logic [2*W-1:0] sq_a, sq_b, sq_out;
    logic [MW-1:0]  mag_sq;

    always_comb begin
        sq_a   = ax * ax;
        sq_b   = bx * bx;
        sq_out = outer_rad * outer_rad;
        mag_sq = MW'(sq_a) + MW'(sq_b);
        if (mag_sq < INNER_SQ)
            area = AREA_INNER;
        else if (mag_sq >= MW'(sq_out))
            area = AREA_OUTER;
        else
            area = AREA_BAND;
    end
endmodule

// File: rtl/evs_sector.sv
module evs_sector
    import evs_pkg::*;
#(
    parameter int W         = 16,
    parameter int TAN30_Q15 = 18919
) (
    input  logic [W-1:0]      ax,
    input  logic [W-1:0]      bx,
    input  logic              a_neg,
    input  logic              b_neg,
    output logic [SECT_W-1:0] sector12
);
    localparam int PW = W + 16;

    logic [PW-1:0] ax_sh, bx_sh, ax_t, bx_t;
    logic          lo30_le, lo30_lt, lo60_le, lo60_lt;
    logic          a_zero;
    logic [1:0]    t_le, t_lt;

    always_comb begin
        ax_sh   = PW'(ax) << 15;
        bx_sh   = PW'(bx) << 15;
        ax_t    = PW'(ax) * PW'(TAN30_Q15);
        bx_t    = PW'(bx) * PW'(TAN30_Q15);
        lo30_le = bx_sh <= ax_t;
        lo30_lt = bx_sh <  ax_t;
        lo60_le = bx_t  <= ax_sh;
        lo60_lt = bx_t  <  ax_sh;
        t_le    = sub_region(lo30_le, lo60_le);
        t_lt    = sub_region(lo30_lt, lo60_lt);
        a_zero  = (ax == '0);

        // Quadrants are split so that an exact axis angle falls into
        // the lower-numbered neighbouring sector.
        if (!b_neg && !a_neg)
            sector12 = 4'd1 + SECT_W'(t_le);
        else if (!b_neg)
            sector12 = 4'd6 - SECT_W'(t_lt);
        else if (a_neg || a_zero)
            sector12 = 4'd7 + SECT_W'(t_le);
        else
            sector12 = 4'd12 - SECT_W'(t_lt);
    end
endmodule

// File: rtl/evs_vecmap.sv
module evs_vecmap
    import evs_pkg::*;
(
    input  area_e             area,
    input  logic [SECT_W-1:0] sector12,
    input  logic              balanced,
    input  logic              charge,
    output sel_t              res
);
    logic [SECT_W-1:0] s6;
    logic [SECT_W-1:0] pair_idx;

    always_comb begin
        s6       = fold_to_six(sector12);
        pair_idx = (sector12 - 4'd1) >> 1;
        res.area = area;
        if (area == AREA_INNER) begin
            res.sector = '0;
            res.vec    = '0;
            res.zero   = 1'b1;
        end else if (balanced) begin
            res.sector = sector12;
            res.vec    = (sector12[0] ? BASE_LRG : BASE_MED) + VEC_W'(pair_idx);
            res.zero   = 1'b0;
        end else begin
            res.sector = s6;
            res.vec    = (charge ? BASE_CHG : BASE_DIS) + VEC_W'(s6 - 4'd1);
            res.zero   = 1'b0;
        end
    end
endmodule

// File: rtl/errvec_selector.sv
module errvec_selector
    import evs_pkg::*;
#(
    parameter int W         = 16,
    parameter int INNER_RAD = 64,
    parameter int TAN30_Q15 = 18919
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] err_alpha,
    input  logic signed [W-1:0] err_beta,
    input  logic [W-1:0]        outer_rad,
    input  logic                np_balanced,
    input  logic                cap_charge,
    output logic                out_valid,
    output logic [1:0]          out_area,
    output logic [SECT_W-1:0]   out_sector,
    output logic [VEC_W-1:0]    out_vec,
    output logic                out_zero
);
    logic [W-1:0]      ax, bx;
    logic              a_neg, b_neg;
    area_e             area;
    logic [SECT_W-1:0] sector12;
    sel_t              next_res, res_q;

    always_comb begin
        a_neg = err_alpha[W-1];
        b_neg = err_beta[W-1];
        ax    = a_neg ? W'(-err_alpha) : W'(err_alpha);
        bx    = b_neg ? W'(-err_beta)  : W'(err_beta);
    end

    evs_area #(.W(W), .INNER_RAD(INNER_RAD)) u_area (
        .ax(ax), .bx(bx), .outer_rad(outer_rad), .area(area)
    );

    evs_sector #(.W(W), .TAN30_Q15(TAN30_Q15)) u_sector (
        .ax(ax), .bx(bx), .a_neg(a_neg), .b_neg(b_neg), .sector12(sector12)
    );

    evs_vecmap u_map (
        .area(area), .sector12(sector12), .balanced(np_balanced),
        .charge(cap_charge), .res(next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                res_q <= next_res;
        end
    end

    assign out_area   = res_q.area;
    assign out_sector = res_q.sector;
    assign out_vec    = res_q.vec;
    assign out_zero   = res_q.zero;
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                np_balanced,
    input logic                cap_charge,
    input logic                out_valid,
    input logic [1:0]          out_area,
    input logic [3:0]          out_sector,
    input logic [4:0]          out_vec,
    input logic                out_zero
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sector) && $stable(out_vec) && $stable(out_area))); // R2
    AST_ZERO_INNER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero) |-> (out_sector == 4'd0 && out_vec == 5'd0 && out_area == 2'd0)); // R3
    AST_ZERO_ONLY_INNER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_area != 2'd0) |-> !out_zero); // R10
    AST_SECTOR12_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && np_balanced) |=> (out_zero || (out_sector >= 4'd1 && out_sector <= 4'd12))); // R5
    AST_SECTOR6_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !np_balanced) |=> (out_zero || (out_sector >= 4'd1 && out_sector <= 4'd6))); // R7
    AST_BAL_FAMILY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && np_balanced) |=> (out_zero || (out_vec >= 5'd8 && out_vec <= 5'd13)
                                        || (out_vec >= 5'd15 && out_vec <= 5'd20))); // R6
    AST_CHG_FAMILY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !np_balanced && cap_charge) |=> (out_zero || (out_vec >= 5'd1 && out_vec <= 5'd6))); // R8
    AST_DIS_FAMILY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !np_balanced && !cap_charge) |=> (out_zero || (out_vec >= 5'd21 && out_vec <= 5'd26))); // R8
endmodule

bind errvec_selector evs_checker #(.W(W)) u_evs_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .np_balanced(np_balanced),
    .cap_charge(cap_charge), .out_valid(out_valid), .out_area(out_area),
    .out_sector(out_sector), .out_vec(out_vec), .out_zero(out_zero)
);

// File: tb/test_errvec_selector.sv
module test_errvec_selector;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    typedef struct packed {
        logic signed [15:0] a;
        logic signed [15:0] b;
        logic [15:0]        r;
        logic               bal;
        logic               chg;
        logic [1:0]         area;
        logic [3:0]         sec;
        logic [4:0]         vec;
        logic               zero;
    } stim_t;

    localparam int NV = 34;
    localparam stim_t TBL [NV] = '{
        // R5 R6: balanced sweep at mid-sector angles, band area
        '{ 16'sd483,   16'sd129, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd1,  5'd15, 1'b0},
        '{ 16'sd354,   16'sd354, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd2,  5'd8,  1'b0},
        '{ 16'sd129,   16'sd483, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd3,  5'd16, 1'b0},
        '{-16'sd129,   16'sd483, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd4,  5'd9,  1'b0},
        '{-16'sd354,   16'sd354, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd5,  5'd17, 1'b0},
        '{-16'sd483,   16'sd129, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd6,  5'd10, 1'b0},
        '{-16'sd483,  -16'sd129, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd7,  5'd18, 1'b0},
        '{-16'sd354,  -16'sd354, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd8,  5'd11, 1'b0},
        '{-16'sd129,  -16'sd483, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd9,  5'd19, 1'b0},
        '{ 16'sd129,  -16'sd483, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd10, 5'd12, 1'b0},
        '{ 16'sd354,  -16'sd354, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd11, 5'd20, 1'b0},
        '{ 16'sd483,  -16'sd129, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd12, 5'd13, 1'b0},
        // R6: charge flag ignored in balanced mode
        '{ 16'sd354,   16'sd354, 16'd1000, 1'b1, 1'b1, 2'd1, 4'd2,  5'd8,  1'b0},
        // R7 R8: unbalanced, charging family
        '{ 16'sd354,   16'sd354, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd1,  5'd1,  1'b0},
        '{-16'sd129,   16'sd483, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd2,  5'd2,  1'b0},
        '{-16'sd483,   16'sd129, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd3,  5'd3,  1'b0},
        '{-16'sd354,  -16'sd354, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd4,  5'd4,  1'b0},
        '{ 16'sd129,  -16'sd483, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd5,  5'd5,  1'b0},
        '{ 16'sd483,  -16'sd129, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd6,  5'd6,  1'b0},
        // R7 R8: unbalanced, discharging family
        '{ 16'sd483,   16'sd129, 16'd1000, 1'b0, 1'b0, 2'd1, 4'd1,  5'd21, 1'b0},
        '{ 16'sd129,   16'sd483, 16'd1000, 1'b0, 1'b0, 2'd1, 4'd2,  5'd22, 1'b0},
        '{-16'sd483,  -16'sd129, 16'd1000, 1'b0, 1'b0, 2'd1, 4'd4,  5'd24, 1'b0},
        '{ 16'sd354,  -16'sd354, 16'd1000, 1'b0, 1'b0, 2'd1, 4'd6,  5'd26, 1'b0},
        // R3: inner ring, both modes
        '{ 16'sd30,    16'sd20,  16'd1000, 1'b1, 1'b0, 2'd0, 4'd0,  5'd0,  1'b1},
        '{-16'sd30,   -16'sd20,  16'd1000, 1'b0, 1'b1, 2'd0, 4'd0,  5'd0,  1'b1},
        // R4 R9: exactly on inner radius at 0 and 90 degrees
        '{ 16'sd64,    16'sd0,   16'd1000, 1'b1, 1'b0, 2'd1, 4'd1,  5'd15, 1'b0},
        '{ 16'sd0,     16'sd64,  16'd1000, 1'b1, 1'b0, 2'd1, 4'd3,  5'd16, 1'b0},
        // R9: axis angles 180 and 270, both modes; 90 unbalanced
        '{-16'sd500,   16'sd0,   16'd1000, 1'b1, 1'b0, 2'd1, 4'd6,  5'd10, 1'b0},
        '{-16'sd500,   16'sd0,   16'd1000, 1'b0, 1'b1, 2'd1, 4'd3,  5'd3,  1'b0},
        '{ 16'sd0,    -16'sd500, 16'd1000, 1'b1, 1'b0, 2'd1, 4'd9,  5'd19, 1'b0},
        '{ 16'sd0,    -16'sd500, 16'd1000, 1'b0, 1'b0, 2'd1, 4'd5,  5'd25, 1'b0},
        '{ 16'sd0,     16'sd500, 16'd1000, 1'b0, 1'b1, 2'd1, 4'd2,  5'd2,  1'b0},
        // R4 R10: exactly on outer radius, then just inside it
        '{ 16'sd300,   16'sd400, 16'd500,  1'b1, 1'b0, 2'd2, 4'd2,  5'd8,  1'b0},
        '{ 16'sd300,   16'sd400, 16'd501,  1'b1, 1'b0, 2'd1, 4'd2,  5'd8,  1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [W-1:0] err_alpha = '0;
    logic signed [W-1:0] err_beta = '0;
    logic [W-1:0]      outer_rad = '0;
    logic              np_balanced = 1'b1;
    logic              cap_charge = 1'b0;
    logic              out_valid;
    logic [1:0]        out_area;
    logic [3:0]        out_sector;
    logic [4:0]        out_vec;
    logic              out_zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errvec_selector #(.W(W)) i_errvec_selector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .err_alpha(err_alpha),
        .err_beta(err_beta), .outer_rad(outer_rad), .np_balanced(np_balanced),
        .cap_charge(cap_charge), .out_valid(out_valid), .out_area(out_area),
        .out_sector(out_sector), .out_vec(out_vec), .out_zero(out_zero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic apply(input stim_t s);
        @(negedge clk);
        err_alpha   = s.a;
        err_beta    = s.b;
        outer_rad   = s.r;
        np_balanced = s.bal;
        cap_charge  = s.chg;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid    = 1'b0;
    endtask

    task automatic check_result(input stim_t s, input string req);
        check(out_valid == 1'b1, req, "valid", int'(out_valid), 1);
        check(out_area == s.area, req, "area", int'(out_area), int'(s.area));
        check(out_sector == s.sec, req, "sector", int'(out_sector), int'(s.sec));
        check(out_vec == s.vec, req, "vector", int'(out_vec), int'(s.vec));
        check(out_zero == s.zero, req, "zero", int'(out_zero), int'(s.zero));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid", int'(out_valid), 0);
        check(out_sector == 4'd0, "R1", "sector", int'(out_sector), 0);
        check(out_vec == 5'd0, "R1", "vector", int'(out_vec), 0);
        check(out_area == 2'd0 && out_zero == 1'b0, "R1", "area/zero",
              int'({out_area, out_zero}), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check_result(TBL[i], "R5-R10 table");
        end

        // R2: idle cycle -> valid low, results held from last sample
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "idle valid", int'(out_valid), 0);
        check(out_sector == TBL[NV-1].sec, "R2", "held sector",
              int'(out_sector), int'(TBL[NV-1].sec));
        check(out_vec == TBL[NV-1].vec, "R2", "held vector",
              int'(out_vec), int'(TBL[NV-1].vec));

        // R2: inputs changing without a strobe do not reach the outputs
        err_alpha = -16'sd354; err_beta = -16'sd354; np_balanced = 1'b1;
        @(negedge clk);
        check(out_sector == TBL[NV-1].sec, "R2", "no-strobe sector",
              int'(out_sector), int'(TBL[NV-1].sec));

        // R4 R5: full-scale negative corner, 225 degrees, outer area
        apply('{-16'sd32768, -16'sd32768, 16'd1000, 1'b1, 1'b0, 2'd2, 4'd8, 5'd11, 1'b0});
        check_result('{-16'sd32768, -16'sd32768, 16'd1000, 1'b1, 1'b0, 2'd2, 4'd8, 5'd11, 1'b0},
                     "R4 R5 full-scale");

        // R1: reset during operation clears results
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(out_vec == 5'd0 && out_sector == 4'd0, "R1", "mid reset vec/sector",
              int'({out_sector, out_vec}), 0);
        check(out_area == 2'd0 && out_valid == 1'b0, "R1", "mid reset area/valid",
              int'({out_area, out_valid}), 0);
        rst = 1'b0;

        finish_run();
    end
endmodule